// File: doc/BRIEF.md
# Register Rename and In-Order Retire Unit

This block is the renaming front end of a small two-way issue machine. Each cycle it may take a pair of decoded instructions. Each instruction carries an operation class (integer add or integer multiply), two source register numbers and one destination register number. For every source the block looks up a map table. The entry gives either the committed register value or the rename buffer that will produce the newest value. The block then gives each destination its own rename buffer and places the instruction, with its operands in value or tag form, into a waiting station in front of the adder or the multiplier.

Results are broadcast with their buffer tag. The broadcast marks the buffer as complete, and every operand waiting on that tag takes the value. Buffers leave the pool one at a time and strictly in allocation order. A retiring buffer updates the architectural register only if the map entry of that register still names it. Otherwise the result has already been superseded, and it is dropped. A combinational read port shows the committed value of any register.

Top module: `rename_retire_unit`

## Requirements
- R1: After reset, register k holds the committed value k, no register is mapped to a buffer, all four buffers are free, `ret_valid` is 0 and `in_ready` is 1 for any pair.
- R2: Committed register values equal sequential execution of the accepted stream in program order, where `in_op[i]`=0 means add and 1 means multiply, modulo 2^16.
- R3: When slot 1 reads the destination of slot 0 in the same pair, it uses slot 0's result and not the older mapping.
- R4: When both slots of a pair write the same register, the committed value afterwards is the one produced by slot 1.
- R5: A source that is unmapped takes the committed value. A source mapped to a completed buffer takes that buffer's value. A source mapped to a pending buffer waits for its tag, including a broadcast that arrives in the rename cycle.
- R6: On an idle unit, an add accepted at clock edge E has `ret_valid` high in the cycle after edge E+2. A multiply has it in the cycle after edge E+3. The adder takes one cycle and the multiplier two.
- R7: Buffers are given out in rising circular order from 0, and slot 0 gets its buffer before slot 1. So the n-th retirement since reset reports `ret_tag` = n mod 4.
- R8: Retirements appear in program order, one per cycle at most. A younger completed result waits while an older buffer is still pending.
- R9: A retiring buffer with `ret_write`=1 commits `ret_value` to `ret_areg`. This happens only when the map entry still names the buffer. With `ret_write`=0 the committed value does not change.
- R10: `in_ready` is 0 whenever the free buffers are fewer than the enabled slots of the pair, or a station lacks entries for them. A pair is accepted whole or not at all.
- R11: `in_slot_en[i]` enables slot i. A disabled slot allocates no buffer and has no effect.
- R12: `rd_data` shows the committed value of register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | The offered pair can be accepted whole |
| in_slot_en | input | 2 | Per-slot enable, bit 0 is the older slot |
| in_op | input | 2 | Per-slot class, 0 add, 1 multiply |
| in_src_a | input | 6 | First source register of each slot, 3 bits per slot |
| in_src_b | input | 6 | Second source register of each slot |
| in_dst | input | 6 | Destination register of each slot |
| ret_valid | output | 1 | A buffer retires this cycle |
| ret_tag | output | 2 | Retiring buffer number |
| ret_areg | output | 3 | Destination register of the retiring buffer |
| ret_value | output | 16 | Result held by the retiring buffer |
| ret_write | output | 1 | The result is committed (mapping still names the buffer) |
| rd_addr | input | 3 | Committed-value read address |
| rd_data | output | 16 | Committed value of `rd_addr` |

## Verification
The rename path is swept over every combination of slot enables, operation classes and four dependence shapes inside a pair: independent, one source reading the older destination, both sources reading it, and both slots writing one register. These separate correct same-pair forwarding from a stale map lookup, and last-writer-wins from older-writer-wins. A long pseudo-random stream then mixes waits on pending tags with same-cycle broadcasts and buffer wrap-around. Directed cases pin down the retire latency of each unit on an idle machine, the stall once all buffers are in use, and a superseded multiply that retires without a commit while the younger add commits.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int DW    = 16;
    localparam int NAREG = 8;
    localparam int NBUF  = 4;
    localparam int NRS   = 4;
    localparam int NSLOT = 2;
    localparam int NBC   = 2;
    localparam int AW    = $clog2(NAREG);
    localparam int TW    = $clog2(NBUF);
    localparam int CW    = $clog2(NRS + 1);

    typedef struct packed {
        logic          mapped;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } map_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] areg;
        logic [DW-1:0] val;
    } rbuf_t;

    typedef struct packed {
        logic          rdy;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } bcast_t;

    typedef struct packed {
        logic          busy;
        opnd_t         a;
        opnd_t         b;
        logic [TW-1:0] dst;
    } rse_t;
endpackage

// File: rtl/rr_src_resolve.sv
module rr_src_resolve
    import rr_pkg::*;
(
    input  map_t                     ent,
    input  logic [NBUF-1:0]          bvalid,
    input  logic [NBUF-1:0][DW-1:0]  bval,
    input  bcast_t [NBC-1:0]         bc,
    input  logic                     fwd,
    input  logic [TW-1:0]            fwd_tag,
    output opnd_t                    opnd
);
    always_comb begin
        opnd = '0;
        if (fwd) begin
            opnd.tag = fwd_tag;
        end else if (!ent.mapped) begin
            opnd.rdy = 1'b1;
            opnd.val = ent.val;
        end else if (bvalid[ent.tag]) begin
            opnd.rdy = 1'b1;
            opnd.val = bval[ent.tag];
        end else begin
            opnd.tag = ent.tag;
            for (int k = 0; k < NBC; k++) begin
                if (bc[k].vld && bc[k].tag == ent.tag) begin
                    opnd.rdy = 1'b1;
                    opnd.val = bc[k].val;
                end
            end
        end
    end
endmodule

// File: rtl/rr_station.sv
module rr_station
    import rr_pkg::*;
#(
    parameter bit IS_MUL = 1'b0,
    parameter int LAT    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSLOT-1:0]            ins_vld,
    input  opnd_t [NSLOT-1:0]           ins_a,
    input  opnd_t [NSLOT-1:0]           ins_b,
    input  logic [NSLOT-1:0][TW-1:0]    ins_dst,
    input  bcast_t [NBC-1:0]            bc,
    output logic [CW-1:0]               free_cnt,
    output bcast_t                      res
);
    typedef struct packed {
        rse_t   [NRS-1:0] ent;
        bcast_t [LAT-1:0] pipe;
    } st_t;

    st_t st_d, st_q;
    logic [NRS-1:0][DW-1:0] ent_res;
    logic [NRS-1:0]         used;
    logic                   placed;
    logic                   found;
    bcast_t                 iss;

    for (genvar e = 0; e < NRS; e++) begin : g_fn
        if (IS_MUL) begin : g_mul
            assign ent_res[e] = st_q.ent[e].a.val * st_q.ent[e].b.val;
        end else begin : g_add
            assign ent_res[e] = st_q.ent[e].a.val + st_q.ent[e].b.val;
        end
    end

    always_comb begin
        st_d   = st_q;
        used   = '0;
        placed = 1'b0;
        found  = 1'b0;
        iss    = '0;
        // capture broadcasts into waiting operands
        for (int e = 0; e < NRS; e++) begin
            for (int k = 0; k < NBC; k++) begin
                if (st_q.ent[e].busy && bc[k].vld) begin
                    if (!st_q.ent[e].a.rdy && st_q.ent[e].a.tag == bc[k].tag) begin
                        st_d.ent[e].a.rdy = 1'b1;
                        st_d.ent[e].a.val = bc[k].val;
                    end
                    if (!st_q.ent[e].b.rdy && st_q.ent[e].b.tag == bc[k].tag) begin
                        st_d.ent[e].b.rdy = 1'b1;
                        st_d.ent[e].b.val = bc[k].val;
                    end
                end
            end
        end
        // issue the lowest ready entry
        for (int e = 0; e < NRS; e++) begin
            if (!found && st_q.ent[e].busy && st_q.ent[e].a.rdy && st_q.ent[e].b.rdy) begin
                found            = 1'b1;
                iss.vld          = 1'b1;
                iss.tag          = st_q.ent[e].dst;
                iss.val          = ent_res[e];
                st_d.ent[e].busy = 1'b0;
            end
        end
        st_d.pipe[0] = iss;
        for (int s = 1; s < LAT; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        // insert accepted slots into free entries, older slot first
        for (int i = 0; i < NSLOT; i++) begin
            placed = 1'b0;
            for (int e = 0; e < NRS; e++) begin
                if (ins_vld[i] && !placed && !st_q.ent[e].busy && !used[e]) begin
                    used[e]          = 1'b1;
                    placed           = 1'b1;
                    st_d.ent[e].busy = 1'b1;
                    st_d.ent[e].a    = ins_a[i];
                    st_d.ent[e].b    = ins_b[i];
                    st_d.ent[e].dst  = ins_dst[i];
                end
            end
        end
        free_cnt = '0;
        for (int e = 0; e < NRS; e++) begin
            free_cnt = free_cnt + CW'(!st_q.ent[e].busy);
        end
    end

    assign res = st_q.pipe[LAT-1];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rename_retire_unit.sv
module rename_retire_unit
    import rr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NSLOT-1:0]      in_slot_en,
    input  logic [NSLOT-1:0]      in_op,
    input  logic [NSLOT*AW-1:0]   in_src_a,
    input  logic [NSLOT*AW-1:0]   in_src_b,
    input  logic [NSLOT*AW-1:0]   in_dst,
    output logic                  ret_valid,
    output logic [TW-1:0]         ret_tag,
    output logic [AW-1:0]         ret_areg,
    output logic [DW-1:0]         ret_value,
    output logic                  ret_write,
    input  logic [AW-1:0]         rd_addr,
    output logic [DW-1:0]         rd_data
);
    typedef struct packed {
        map_t  [NAREG-1:0] map;
        rbuf_t [NBUF-1:0]  bufs;
        logic  [TW-1:0]    ap;
        logic  [TW-1:0]    rp;
        logic  [TW:0]      cnt;
    } st_t;

    function automatic st_t reset_state();
        st_t s;
        s = '0;
        for (int k = 0; k < NAREG; k++) s.map[k].val = DW'(k);
        return s;
    endfunction

    st_t st_d, st_q;

    int                          n_need, n_add, n_mul;
    logic [NSLOT-1:0][TW-1:0]    slot_tag;
    logic [NSLOT-1:0]            fwd_a, fwd_b;
    logic [NSLOT-1:0][TW-1:0]    ftag_a, ftag_b;
    logic [NBUF-1:0]             bvalid;
    logic [NBUF-1:0][DW-1:0]     bval;
    logic [NAREG-1:0][DW-1:0]    commit_vals;
    opnd_t [NSLOT-1:0]           opa, opb;
    bcast_t [NBC-1:0]            bc;
    logic [CW-1:0]               add_free, mul_free;
    logic                        accept;
    logic [NSLOT-1:0]            add_vld, mul_vld;

    // slot decode: tags in program order, same-pair forwarding
    always_comb begin
        n_need = 0;
        n_add  = 0;
        n_mul  = 0;
        for (int i = 0; i < NSLOT; i++) begin
            slot_tag[i] = st_q.ap + TW'(n_need);
            if (in_slot_en[i]) begin
                n_need++;
                if (in_op[i]) n_mul++;
                else          n_add++;
            end
        end
        for (int i = 0; i < NSLOT; i++) begin
            fwd_a[i]  = 1'b0;
            fwd_b[i]  = 1'b0;
            ftag_a[i] = '0;
            ftag_b[i] = '0;
            for (int j = 0; j < NSLOT; j++) begin
                if (j < i && in_slot_en[j]) begin
                    if (in_dst[j*AW +: AW] == in_src_a[i*AW +: AW]) begin
                        fwd_a[i]  = 1'b1;
                        ftag_a[i] = slot_tag[j];
                    end
                    if (in_dst[j*AW +: AW] == in_src_b[i*AW +: AW]) begin
                        fwd_b[i]  = 1'b1;
                        ftag_b[i] = slot_tag[j];
                    end
                end
            end
        end
        for (int k = 0; k < NBUF; k++) begin
            bvalid[k] = st_q.bufs[k].valid;
            bval[k]   = st_q.bufs[k].val;
        end
        for (int k = 0; k < NAREG; k++) commit_vals[k] = st_q.map[k].val;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        rr_src_resolve u_ra (
            .ent     (st_q.map[in_src_a[i*AW +: AW]]),
            .bvalid  (bvalid),
            .bval    (bval),
            .bc      (bc),
            .fwd     (fwd_a[i]),
            .fwd_tag (ftag_a[i]),
            .opnd    (opa[i])
        );
        rr_src_resolve u_rb (
            .ent     (st_q.map[in_src_b[i*AW +: AW]]),
            .bvalid  (bvalid),
            .bval    (bval),
            .bc      (bc),
            .fwd     (fwd_b[i]),
            .fwd_tag (ftag_b[i]),
            .opnd    (opb[i])
        );
    end

    assign in_ready = (int'(NBUF) - int'(st_q.cnt) >= n_need)
                   && (int'(add_free) >= n_add)
                   && (int'(mul_free) >= n_mul);
    assign accept   = in_valid && in_ready;
    assign add_vld  = in_slot_en & ~in_op & {NSLOT{accept}};
    assign mul_vld  = in_slot_en &  in_op & {NSLOT{accept}};

    rr_station #(.IS_MUL(1'b0), .LAT(1)) u_add_rs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_vld  (add_vld),
        .ins_a    (opa),
        .ins_b    (opb),
        .ins_dst  (slot_tag),
        .bc       (bc),
        .free_cnt (add_free),
        .res      (bc[0])
    );

    rr_station #(.IS_MUL(1'b1), .LAT(2)) u_mul_rs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_vld  (mul_vld),
        .ins_a    (opa),
        .ins_b    (opb),
        .ins_dst  (slot_tag),
        .bc       (bc),
        .free_cnt (mul_free),
        .res      (bc[1])
    );

    assign ret_valid = (st_q.cnt != '0) && st_q.bufs[st_q.rp].valid;
    assign ret_tag   = st_q.rp;
    assign ret_areg  = st_q.bufs[st_q.rp].areg;
    assign ret_value = st_q.bufs[st_q.rp].val;
    assign ret_write = ret_valid && st_q.map[ret_areg].mapped
                    && (st_q.map[ret_areg].tag == st_q.rp);
    assign rd_data   = commit_vals[rd_addr];

    always_comb begin
        st_d = st_q;
        // retire first so a same-cycle rename of the register wins the mapping
        if (ret_valid) begin
            if (ret_write) begin
                st_d.map[ret_areg].val    = ret_value;
                st_d.map[ret_areg].mapped = 1'b0;
            end
            st_d.rp = st_q.rp + 1'b1;
        end
        for (int k = 0; k < NBC; k++) begin
            if (bc[k].vld) begin
                st_d.bufs[bc[k].tag].valid = 1'b1;
                st_d.bufs[bc[k].tag].val   = bc[k].val;
            end
        end
        if (accept) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (in_slot_en[i]) begin
                    st_d.bufs[slot_tag[i]].valid = 1'b0;
                    st_d.bufs[slot_tag[i]].areg  = in_dst[i*AW +: AW];
                    st_d.bufs[slot_tag[i]].val   = '0;
                    st_d.map[in_dst[i*AW +: AW]].mapped = 1'b1;
                    st_d.map[in_dst[i*AW +: AW]].tag    = slot_tag[i];
                end
            end
            st_d.ap = st_q.ap + TW'(n_need);
        end
        st_d.cnt = st_q.cnt + (accept ? (TW+1)'(n_need) : '0) - (TW+1)'(ret_valid);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rr_checker.sv
module rr_checker
    import rr_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [NSLOT-1:0]          in_slot_en,
    input logic                      ret_valid,
    input logic [TW-1:0]             ret_tag,
    input logic [AW-1:0]             ret_areg,
    input logic [DW-1:0]             ret_value,
    input logic                      ret_write,
    input logic [TW:0]               cnt,
    input logic [NAREG-1:0][DW-1:0]  cvals
);
    logic [TW-1:0] exp_tag;

    always_ff @(posedge clk) begin
        if (!rst_n)         exp_tag <= '0;
        else if (ret_valid) exp_tag <= exp_tag + 1'b1;
    end

    AST_RETIRE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ret_tag == exp_tag); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= NBUF); // R10

    AST_ACCEPT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (int'(NBUF) - int'(cnt) >= int'($countones(in_slot_en)))); // R10

    AST_COMMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_write) |=> cvals[$past(ret_areg)] == $past(ret_value)); // R9

    AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_write) |=> cvals[$past(ret_areg)] == $past(cvals[ret_areg])); // R9
endmodule

bind rename_retire_unit rr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_slot_en (in_slot_en),
    .ret_valid  (ret_valid),
    .ret_tag    (ret_tag),
    .ret_areg   (ret_areg),
    .ret_value  (ret_value),
    .ret_write  (ret_write),
    .cnt        (st_q.cnt),
    .cvals      (commit_vals)
);

// File: tb/rename_retire_unit_tb.sv
module rename_retire_unit_tb;
    import rr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXE       = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [NSLOT-1:0]     in_slot_en = '0;
    logic [NSLOT-1:0]     in_op = '0;
    logic [NSLOT*AW-1:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic                 ret_valid, ret_write;
    logic [TW-1:0]        ret_tag;
    logic [AW-1:0]        ret_areg;
    logic [DW-1:0]        ret_value;
    logic [AW-1:0]        rd_addr = '0;
    logic [DW-1:0]        rd_data;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    logic [DW-1:0] mreg [NAREG];
    int exp_areg [MAXE];
    int exp_val  [MAXE];
    int exp_wr   [MAXE];
    int n_exp = 0;
    int n_ret = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_retire_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_slot_en(in_slot_en), .in_op(in_op), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .ret_valid(ret_valid),
        .ret_tag(ret_tag), .ret_areg(ret_areg), .ret_value(ret_value),
        .ret_write(ret_write), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] exec_op(input logic op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        if (op) r = a * b;
        else    r = a + b;
        return r;
    endfunction

    // retire monitor: program order (R8), values (R2), tags (R7), write flag where known (R9)
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (n_ret < n_exp) begin
                check(int'(ret_areg) == exp_areg[n_ret], "R8 retire areg", int'(ret_areg), exp_areg[n_ret]);
                check(int'(ret_value) == exp_val[n_ret], "R2 retire value", int'(ret_value), exp_val[n_ret]);
                check(int'(ret_tag) == n_ret % NBUF, "R7 retire tag", int'(ret_tag), n_ret % NBUF);
                if (exp_wr[n_ret] >= 0)
                    check(int'(ret_write) == exp_wr[n_ret], "R9 write flag", int'(ret_write), exp_wr[n_ret]);
            end else begin
                check(1'b0, "R8 unexpected retire", n_ret, n_exp);
            end
            n_ret++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic drive(input logic [1:0] en, input logic [1:0] op,
                         input int a0, input int b0, input int d0,
                         input int a1, input int b1, input int d1);
        in_slot_en = en;
        in_op      = op;
        in_src_a   = {AW'(a1), AW'(a0)};
        in_src_b   = {AW'(b1), AW'(b0)};
        in_dst     = {AW'(d1), AW'(d0)};
        in_valid   = 1'b1;
    endtask

    // record accepted pair in the reference model, in program order
    task automatic model_pair(input int wr0, input int wr1);
        for (int i = 0; i < NSLOT; i++) begin
            if (in_slot_en[i]) begin
                logic [DW-1:0] v;
                v = exec_op(in_op[i], mreg[in_src_a[i*AW +: AW]], mreg[in_src_b[i*AW +: AW]]);
                exp_areg[n_exp] = int'(in_dst[i*AW +: AW]);
                exp_val[n_exp]  = int'(v);
                exp_wr[n_exp]   = (i == 0) ? wr0 : wr1;
                n_exp++;
                mreg[in_dst[i*AW +: AW]] = v;
            end
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic issue(input logic [1:0] en, input logic [1:0] op,
                         input int a0, input int b0, input int d0,
                         input int a1, input int b1, input int d1,
                         input int wr0 = -1, input int wr1 = -1);
        drive(en, op, a0, b0, d0, a1, b1, d1);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        model_pair(wr0, wr1);
        @(negedge clk);
        in_valid   = 1'b0;
        in_slot_en = '0;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NAREG; k++) begin
            rd_addr = AW'(k);
            #1;
            check(rd_data == mreg[k], req, int'(rd_data), int'(mreg[k]));
        end
    endtask

    task automatic latency_probe(input logic op, input int lat);
        drive(2'b01, {1'b0, op}, 2, 3, 1, 0, 0, 0);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        model_pair(-1, -1);
        for (int n = 1; n <= lat + 2; n++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_slot_en = '0;
            #1;
            check(ret_valid == (n == lat + 2), "R6 retire latency", int'(ret_valid), int'(n == lat + 2));
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        int base;
        logic [DW-1:0] old;
        for (int k = 0; k < NAREG; k++) mreg[k] = DW'(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        in_slot_en = 2'b11;
        in_op = 2'b11;
        #1;
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(ret_valid == 1'b0, "R1 no retire after reset", int'(ret_valid), 0);
        in_slot_en = '0;
        check_regs("R1 R12 reset value");

        // R6 latencies on an idle unit
        latency_probe(1'b0, 1);
        drain();
        latency_probe(1'b1, 2);
        drain();

        // R3 same-pair read after write
        issue(2'b11, 2'b10, 3, 4, 2, 2, 2, 5);
        drain();
        rd_addr = 3'd5;
        #1;
        check(rd_data == mreg[5], "R3 forwarded operand", int'(rd_data), int'(mreg[5]));

        // R4 same-pair double write
        issue(2'b11, 2'b00, 1, 1, 6, 2, 3, 6, 0, 1);
        drain();
        rd_addr = 3'd6;
        #1;
        check(rd_data == mreg[6], "R4 younger writer wins", int'(rd_data), int'(mreg[6]));

        // R9 superseded multiply retires without commit
        old = mreg[1];
        issue(2'b11, 2'b01, 2, 3, 1, 4, 5, 1, 0, 1);
        rd_addr = 3'd1;
        for (int w = 0; w < 10 && !ret_valid; w++) begin
            @(negedge clk);
            #1;
        end
        check(ret_valid && !ret_write, "R9 dropped retire", int'(ret_write), 0);
        @(negedge clk);
        #1;
        check(rd_data == old, "R9 value kept after drop", int'(rd_data), int'(old));
        check(ret_valid && ret_write, "R9 younger commits", int'(ret_write), 1);
        @(negedge clk);
        #1;
        check(rd_data == mreg[1], "R9 committed value", int'(rd_data), int'(mreg[1]));
        drain();

        // R10 stall with all buffers in use
        issue(2'b11, 2'b11, 2, 3, 1, 1, 2, 6);
        issue(2'b11, 2'b11, 1, 1, 4, 4, 4, 5);
        drive(2'b11, 2'b00, 1, 4, 7, 7, 5, 0);
        #1;
        check(in_ready == 1'b0, "R10 pair stalls when full", int'(in_ready), 0);
        in_slot_en = 2'b01;
        #1;
        check(in_ready == 1'b0, "R10 single stalls when full", int'(in_ready), 0);
        issue(2'b11, 2'b00, 1, 4, 7, 7, 5, 0);
        drain();
        check_regs("R10 R5 values after stall");

        // R2 R3 R4 R11 sweep: enables x classes x dependence shape
        base = 0;
        for (int en = 1; en < 4; en++) begin
            for (int op = 0; op < 4; op++) begin
                for (int dep = 0; dep < 4; dep++) begin
                    int d0, a0, b0, a1, b1, d1;
                    d0 = base % 8; a0 = (base + 1) % 8; b0 = (base + 3) % 8;
                    a1 = (base + 5) % 8; b1 = (base + 6) % 8; d1 = (base + 2) % 8;
                    if (dep == 1) a1 = d0;
                    if (dep == 2) begin a1 = d0; b1 = d0; end
                    if (dep == 3) d1 = d0;
                    issue(2'(en), 2'(op), a0, b0, d0, a1, b1, d1);
                    base++;
                end
            end
        end
        drain();
        check_regs("R2 R3 R4 R11 sweep result");

        // R5 R8 pseudo-random stream
        lfsr = 16'hACE1;
        for (int p = 0; p < 400; p++) begin
            logic [1:0] en;
            for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en = lfsr[1:0];
            if (en == 2'b00) en = 2'b11;
            issue(en, lfsr[3:2], int'(lfsr[6:4]), int'(lfsr[9:7]), int'(lfsr[12:10]),
                  int'(lfsr[15:13]), int'(lfsr[5:3]), int'(lfsr[8:6]));
        end
        drain();
        check_regs("R5 R2 random stream result");
        check(n_ret == n_exp, "R8 retire count", n_ret, n_exp);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule